// File: doc/BRIEF.md
# Parallel ADC Host Sequencer

This block sits on the host side of a 14-bit successive-approximation converter whose result comes out over an 8-bit parallel bus. A single request on a ready/valid handshake starts one complete sample. The block then issues three chip-select falling edges. The first starts acquisition. The second starts conversion and, through the level of the read/convert line, picks the power state the converter enters afterwards. The third, issued only once the end-of-conversion flag has fallen, reads the result. The result is fetched in two halves, steered by the byte-select line: the low byte first and then the high byte. The block joins the two halves and returns a 16-bit sample with a one-cycle strobe.

Every interface timing is a parameter counted in system clock cycles. These are chip-select high and low widths, read/convert setup and hold, acquisition length, data-valid delay and bus release. When the previous sample left the converter in shutdown, or when the sample is the first one after reset, the acquisition phase is stretched to cover the reference wake-up time. A per-request flag turns the bipolar offset-binary code into a sign-extended two's complement value. A watchdog abandons a conversion whose end flag never arrives. The watchdog limit must exceed the wait in cycles that follows the second edge.

Top module: `adc_seq_host`

## Requirements
- R1: While reset is asserted, and for REL_CYC cycles after it, chip select is high, read/convert and byte-select are low, and ready, sample strobe and error are all low. After that, ready rises.
- R2: A request is taken only in a cycle where req_valid and req_ready are both high. Ready falls in the next cycle and stays low until the sequence ends. A request raised while ready is low produces no chip-select edge.
- R3: Each sample drives three chip-select falling edges in order. Read/convert is 0 at the first. At the second it equals cfg_shutdown (1 = shutdown, 0 = standby). At the third it is 1.
- R4: Chip select stays high for at least CSH_CYC cycles and low for at least CSL_CYC cycles.
- R5: Read/convert is stable for at least RC_SU_CYC cycles before each chip-select fall and for at least RC_HD_CYC cycles after it.
- R6: The second falling edge comes at least ACQ_CYC cycles after the first. It comes at least SETTLE_CYC cycles after the first when the previous sample chose shutdown, or when this is the first sample since reset.
- R7: The read edge is issued only after adc_eoc_n has been sampled low, and never earlier than the larger of CSH_CYC and RC_SU_CYC cycles after chip select rises following the second edge.
- R8: The low byte is taken with byte-select 0, at least DV_CYC cycles after the read edge. Byte-select then goes to 1 and the high byte is taken DV_CYC cycles later. The raw code is {high[5:0], low[7:0]}.
- R9: With cfg_signed = 0 the sample is the raw code zero-extended to 16 bits. With cfg_signed = 1 it is the raw code with bit 13 inverted and then sign-extended, so 0x2000 gives 0x0000, 0x3FFF gives 0x1FFF and 0x0000 gives 0xE000.
- R10: Counting from the chip-select rise after the second edge, if adc_eoc_n has not been sampled low in the first EOC_TMO_CYC cycles, eoc_err pulses for one cycle, no sample is returned, no read edge occurs and the block returns to ready. A low flag seen on cycle EOC_TMO_CYC itself still leads to a normal read.
- R11: After a read, chip select stays high and byte-select low for at least REL_CYC cycles before the next acquisition edge.
- R12: smp_valid is a one-cycle pulse. It is raised in the same cycle in which chip select rises at the end of the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request for one sample |
| req_ready | output | 1 | High when a request can be taken |
| cfg_shutdown | input | 1 | Power state after the conversion: 1 shutdown, 0 standby; taken with the request |
| cfg_signed | input | 1 | 1 returns two's complement, 0 returns straight binary; taken with the request |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Converter read/convert select |
| adc_hben | output | 1 | Byte select: 1 high byte, 0 low byte |
| adc_eoc_n | input | 1 | End-of-conversion flag from the converter, active low |
| adc_data | input | BUS_W | Converter byte bus |
| smp_valid | output | 1 | One-cycle strobe for smp_data |
| smp_data | output | SMP_W | Assembled sample |
| eoc_err | output | 1 | One-cycle pulse when the end-of-conversion watchdog expires |

## Verification
The end-of-conversion flag and the watchdog expiry can land in the same cycle: the flag is sampled low on exactly the last allowed cycle. The bench sets the converter model's delay to exactly EOC_TMO_CYC for one request and to one cycle more for the next. The first must return the correct sample with no error pulse. The second must pulse eoc_err with no sample and no read edge. The converter model drives the inverted byte on the bus until the data-valid delay has run out, so a byte captured too early shows up as a wrong sample.

// File: rtl/adc_seq_pkg.sv
// Package adc_seq_pkg
// Shared types and constant helpers for the parallel ADC host sequencer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package adc_seq_pkg;

    // Sequencer phases, in the order a successful sample visits them.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request, ready high
        ST_E1,     // first CS low: start acquisition
        ST_ACQ,    // CS high while the converter tracks the input
        ST_E2,     // second CS low: start conversion, R/C carries power mode
        ST_CONV,   // CS high, waiting for end of conversion
        ST_RDL,    // third CS low, low byte on the bus
        ST_RDH,    // CS still low, high byte on the bus
        ST_REL     // CS high, bus release before the next request
    } seq_st_t;

    // Larger of two integers, for localparam derivation.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
// Module adc_seq_timer
// Down-counting phase timer. A load of length N makes done rise on the
// N-th cycle after the load edge, so a phase entered with a load lasts
// exactly N cycles. Assumes: len >= 1 whenever load is high.
module adc_seq_timer #(
    parameter int W       = 8,
    parameter int RST_LEN = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Count down to zero and hold there until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RST_LEN - 1);
        else if (load)
            cnt_q <= len - W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_pack.sv
// Module adc_seq_pack
// Joins the low and high converter bytes into one code and formats it:
// straight binary zero-extended, or offset binary turned into two's
// complement. Assumes: lo_en comes before hi_en for each sample, and
// SMP_W > RAW_W > BUS_W.
module adc_seq_pack #(
    parameter int BUS_W = 8,
    parameter int RAW_W = 14,
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_en,
    input  logic             hi_en,
    input  logic             sgn,
    input  logic [BUS_W-1:0] bus,
    output logic             valid,
    output logic [SMP_W-1:0] data
);
    localparam int HI_W  = RAW_W - BUS_W;
    localparam int EXT_W = SMP_W - RAW_W;

    logic [BUS_W-1:0] lo_q;
    logic [RAW_W-1:0] raw;
    logic [SMP_W-1:0] fmt;
    logic             sgn_q;

    // Hold the low byte until the high byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= '0;
        else if (lo_en)
            lo_q <= bus;
    end

    assign raw = {bus[HI_W-1:0], lo_q};

    // Flip the code's top bit and replicate it for two's complement.
    always_comb begin
        if (sgn)
            fmt = {{(EXT_W + 1){~raw[RAW_W-1]}}, raw[RAW_W-2:0]};
        else
            fmt = {{EXT_W{1'b0}}, raw};
    end

    // Register the result and a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            sgn_q <= 1'b0;
        end else begin
            valid <= hi_en;
            if (hi_en) begin
                data  <= fmt;
                sgn_q <= sgn;
            end
        end
    end

    AST_SIGNED_UPPER_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sgn_q) |-> (data[SMP_W-1:RAW_W-1] == '0 || data[SMP_W-1:RAW_W-1] == '1)); // R9
    AST_UNSIGNED_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !sgn_q) |-> (data[SMP_W-1:RAW_W] == '0)); // R9
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R12

endmodule

// File: rtl/adc_seq_host.sv
// Module adc_seq_host
// Host-side sequencer for a 14-bit parallel-output SAR converter. It drives
// the acquire, convert and read chip-select edges, waits for end of
// conversion under a watchdog, and reads two bytes to build one sample.
// Assumes: every *_CYC value is already rounded up to whole clock cycles,
// EOC_TMO_CYC exceeds both CSH_CYC and RC_SU_CYC, and adc_eoc_n and
// adc_data are synchronous to clk.
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int CSH_CYC     = 10,
    parameter int CSL_CYC     = 10,
    parameter int RC_SU_CYC   = 15,
    parameter int RC_HD_CYC   = 15,
    parameter int ACQ_CYC     = 500,
    parameter int SETTLE_CYC  = 3000000,
    parameter int DV_CYC      = 20,
    parameter int REL_CYC     = 20,
    parameter int EOC_TMO_CYC = 2000,
    parameter int BUS_W       = 8,
    parameter int RAW_W       = 14,
    parameter int SMP_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             cfg_shutdown,
    input  logic             cfg_signed,
    output logic             adc_cs_n,
    output logic             adc_rc,
    output logic             adc_hben,
    input  logic             adc_eoc_n,
    input  logic [BUS_W-1:0] adc_data,
    output logic             smp_valid,
    output logic [SMP_W-1:0] smp_data,
    output logic             eoc_err
);
    // Phase lengths, each covering every rule that applies to that phase.
    localparam int E_CYC     = imax(imax(CSL_CYC, RC_HD_CYC), 1);
    localparam int ACQ_REST  = imax(imax(ACQ_CYC - E_CYC, CSH_CYC), imax(RC_SU_CYC, 1));
    localparam int WAKE_REST = imax(SETTLE_CYC - E_CYC, ACQ_REST);
    localparam int GAP_CYC   = imax(imax(CSH_CYC, RC_SU_CYC), 1);
    localparam int RD_CYC    = imax(imax(DV_CYC, CSL_CYC), imax(RC_HD_CYC, 1));
    localparam int HB_CYC    = imax(DV_CYC, 1);
    localparam int RL_CYC    = imax(imax(REL_CYC, CSH_CYC), imax(RC_SU_CYC, 1));
    localparam int TMR_MAX   = imax(imax(WAKE_REST, RD_CYC), imax(RL_CYC, E_CYC));
    localparam int TW        = $clog2(TMR_MAX + 1);
    localparam int WW        = $clog2(EOC_TMO_CYC + 1);

    seq_st_t       state_q, state_d;
    logic          sd_q, sgn_q, prev_sd_q;
    logic [WW-1:0] wd_q;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_len;
    logic          lo_en, hi_en;

    adc_seq_timer #(.W(TW), .RST_LEN(RL_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    // Next phase and the timer length to load on entering it.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d = ST_E1;  tmr_load = 1'b1; tmr_len = TW'(E_CYC);
            end
            ST_E1: if (tmr_done) begin
                state_d  = ST_ACQ; tmr_load = 1'b1;
                tmr_len  = prev_sd_q ? TW'(WAKE_REST) : TW'(ACQ_REST);
            end
            ST_ACQ: if (tmr_done) begin
                state_d = ST_E2;  tmr_load = 1'b1; tmr_len = TW'(E_CYC);
            end
            ST_E2: if (tmr_done)
                state_d = ST_CONV;
            ST_CONV:
                if (wd_q >= WW'(GAP_CYC - 1) && !adc_eoc_n) begin
                    state_d = ST_RDL; tmr_load = 1'b1; tmr_len = TW'(RD_CYC);
                end else if (wd_q == WW'(EOC_TMO_CYC - 1)) begin
                    state_d = ST_REL; tmr_load = 1'b1; tmr_len = TW'(RL_CYC);
                end
            ST_RDL: if (tmr_done) begin
                state_d = ST_RDH; tmr_load = 1'b1; tmr_len = TW'(HB_CYC);
            end
            ST_RDH: if (tmr_done) begin
                state_d = ST_REL; tmr_load = 1'b1; tmr_len = TW'(RL_CYC);
            end
            ST_REL: if (tmr_done)
                state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register, request latch and power-mode history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_REL;
            sd_q      <= 1'b0;
            sgn_q     <= 1'b0;
            prev_sd_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                sd_q  <= cfg_shutdown;
                sgn_q <= cfg_signed;
            end
            if (state_q == ST_E2 && state_d == ST_CONV)
                prev_sd_q <= sd_q;
        end
    end

    // Watchdog: cycles spent in the conversion wait.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != ST_CONV)
            wd_q <= '0;
        else
            wd_q <= wd_q + WW'(1);
    end

    // Pin drivers, registered from the next phase so pins move with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_cs_n <= 1'b1;
            adc_rc   <= 1'b0;
            adc_hben <= 1'b0;
            eoc_err  <= 1'b0;
        end else begin
            adc_cs_n <= !(state_d inside {ST_E1, ST_E2, ST_RDL, ST_RDH});
            adc_hben <= (state_d == ST_RDH);
            eoc_err  <= (state_q == ST_CONV) && (state_d == ST_REL);
            unique case (state_d)
                ST_ACQ, ST_E2:           adc_rc <= sd_q;
                ST_CONV, ST_RDL, ST_RDH: adc_rc <= 1'b1;
                default:                 adc_rc <= 1'b0;
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign lo_en     = (state_q == ST_RDL) && (state_d == ST_RDH);
    assign hi_en     = (state_q == ST_RDH) && (state_d == ST_REL);

    adc_seq_pack #(.BUS_W(BUS_W), .RAW_W(RAW_W), .SMP_W(SMP_W)) u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_en (lo_en),
        .hi_en (hi_en),
        .sgn   (sgn_q),
        .bus   (adc_data),
        .valid (smp_valid),
        .data  (smp_data)
    );

    AST_READ_AFTER_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_cs_n) && state_q == ST_RDL) |-> $past(!adc_eoc_n)); // R7
    AST_RC_STEADY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> $stable(adc_rc)); // R5
    AST_ACQ_EDGE_RC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_cs_n) && state_q == ST_E1) |-> !adc_rc); // R3
    AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (adc_cs_n && !adc_hben && !adc_rc)); // R11
    AST_HBEN_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        adc_hben |-> !adc_cs_n); // R8
    AST_READY_DROP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid)); // R2
    AST_OUTCOME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && eoc_err)); // R10
    AST_TIMED_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_done && state_q inside {ST_E1, ST_ACQ, ST_E2, ST_RDL, ST_RDH, ST_REL})
        |=> (state_q == $past(state_q))); // R4

endmodule

// File: tb/adc_seq_host_bench.sv
// Bench for adc_seq_host: a cycle-level converter model, pin timing
// monitors, directed corner cases and seeded random requests.
module adc_seq_host_bench;
    localparam int CSH = 3, CSL = 3, SU = 2, HD = 2, ACQ = 20, SETTLE = 200;
    localparam int DV = 4, REL = 5, TMO = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, cfg_shutdown = 1'b0, cfg_signed = 1'b0;
    logic        req_ready, adc_cs_n, adc_rc, adc_hben, smp_valid, eoc_err;
    logic        adc_eoc_n = 1'b1;
    logic [7:0]  adc_data = 8'h00;
    logic [15:0] smp_data;

    always #2 clk = ~clk;

    adc_seq_host #(
        .CSH_CYC(CSH), .CSL_CYC(CSL), .RC_SU_CYC(SU), .RC_HD_CYC(HD),
        .ACQ_CYC(ACQ), .SETTLE_CYC(SETTLE), .DV_CYC(DV), .REL_CYC(REL),
        .EOC_TMO_CYC(TMO), .BUS_W(8), .RAW_W(14), .SMP_W(16)
    ) u_adc_seq_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .cfg_shutdown(cfg_shutdown), .cfg_signed(cfg_signed),
        .adc_cs_n(adc_cs_n), .adc_rc(adc_rc), .adc_hben(adc_hben),
        .adc_eoc_n(adc_eoc_n), .adc_data(adc_data),
        .smp_valid(smp_valid), .smp_data(smp_data), .eoc_err(eoc_err)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected sample from the requirement, not from the design.
    function automatic logic [15:0] exp_sample(input logic [13:0] code, input bit sgn);
        int v;
        if (sgn) begin
            v = int'(code) - 8192;
            return 16'(v);
        end
        return {2'b00, code};
    endfunction

    // Converter model and pin monitors, all at the falling clock edge.
    int          cyc = 0, rc_age = 1000, fall_cyc = 0, rise_cyc = -1000, e1_cyc = 0;
    int          phase = 0, conv_cnt = 0, do_age = 0, fall_tot = 0;
    int          n_valid = 0, n_err = 0, conv_dly = 10;
    bit          prev_sd = 1'b1, hold_pend = 1'b0, exp_sd = 1'b0;
    logic        cs_p = 1'b1, rc_p = 1'b0, hb_p = 1'b0;
    logic [13:0] next_code = '0, conv_code = '0;
    logic [15:0] last_data = '0;
    logic [7:0]  good_byte;

    always @(negedge clk) begin
        bit fell, rose, rc_ch;
        cyc++;
        fell  = cs_p && !adc_cs_n;
        rose  = !cs_p && adc_cs_n;
        rc_ch = (adc_rc != rc_p);
        if (rst_n) begin
            if (rc_ch && hold_pend) begin
                check(cyc - fall_cyc >= HD, "R5 rc hold", cyc - fall_cyc, HD);
                hold_pend = 1'b0;
            end
            if (fell) begin
                check(!rc_ch && rc_age + 1 >= SU, "R5 rc setup", rc_ch ? 0 : rc_age + 1, SU);
                check(cyc - rise_cyc >= CSH, "R4 cs high width", cyc - rise_cyc, CSH);
                fall_tot++;
                if (phase == 1) begin
                    check(cyc - e1_cyc >= (prev_sd ? SETTLE : ACQ), "R6 acquisition length",
                          cyc - e1_cyc, prev_sd ? SETTLE : ACQ);
                    check(adc_rc == exp_sd, "R3 mode bit at convert edge", adc_rc, exp_sd);
                    prev_sd   = adc_rc;
                    phase     = 2;
                    conv_cnt  = 0;
                    adc_eoc_n = 1'b1;
                    conv_code = next_code;
                end else if (phase == 2 && adc_rc) begin
                    check(!adc_eoc_n, "R7 read edge after eoc", adc_eoc_n, 0);
                    phase = 3;
                end else if (!adc_rc) begin
                    if (phase == 0)
                        check(cyc - rise_cyc >= REL, "R11 release gap", cyc - rise_cyc, REL);
                    check(phase != 1 && phase != 3, "R3 edge order", phase, 0);
                    phase  = 1;
                    e1_cyc = cyc;
                end else begin
                    check(1'b0, "R3 unexpected read edge", phase, 2);
                end
                fall_cyc  = cyc;
                hold_pend = 1'b1;
            end
            if (rose) begin
                check(cyc - fall_cyc >= CSL, "R4 cs low width", cyc - fall_cyc, CSL);
                rise_cyc = cyc;
                if (phase == 3) phase = 0;
            end
            if (phase == 2 && adc_cs_n) begin
                conv_cnt++;
                if (conv_cnt >= conv_dly) adc_eoc_n = 1'b0;
            end
            if (smp_valid) begin
                n_valid++;
                last_data = smp_data;
                check(rose, "R12 strobe with cs release", rose, 1);
            end
            if (eoc_err) n_err++;
        end
        if (fell || adc_hben != hb_p) do_age = 0; else do_age++;
        good_byte = adc_hben ? {2'b00, conv_code[13:8]} : conv_code[7:0];
        adc_data  = (do_age >= DV - 1 && !adc_cs_n) ? good_byte : ~good_byte;
        rc_age = rc_ch ? 0 : rc_age + 1;
        cs_p = adc_cs_n; rc_p = adc_rc; hb_p = adc_hben;
    end

    // One request: wait for ready, request, optionally poke while busy, judge.
    task automatic run(input logic [13:0] code, input bit sd, input bit sgn,
                       input int dly, input bit poke);
        int g, nv0, ne0, f0;
        g = 0;
        while (!req_ready && g < 5000) begin @(negedge clk); g++; end
        next_code = code; conv_dly = dly; exp_sd = sd;
        cfg_shutdown = sd; cfg_signed = sgn;
        nv0 = n_valid; ne0 = n_err;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 ready drops after accept", req_ready, 0);
        if (poke) begin
            repeat (4) @(negedge clk);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        g = 0;
        while (n_valid == nv0 && n_err == ne0 && g < 5000) begin @(negedge clk); g++; end
        @(negedge clk);
        if (dly <= TMO) begin
            check(n_valid == nv0 + 1, "R8 one sample returned", n_valid - nv0, 1);
            check(last_data == exp_sample(code, sgn), "R9 sample value",
                  last_data, exp_sample(code, sgn));
            check(n_err == ne0, "R10 no watchdog error", n_err - ne0, 0);
        end else begin
            check(n_err == ne0 + 1, "R10 watchdog error pulse", n_err - ne0, 1);
            check(n_valid == nv0, "R10 no sample on timeout", n_valid - nv0, 0);
        end
        if (poke) begin
            f0 = fall_tot;
            repeat (40) @(negedge clk);
            check(fall_tot == f0, "R2 busy request ignored", fall_tot - f0, 0);
            check(req_ready, "R2 ready back after ignored request", req_ready, 1);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        repeat (5) @(negedge clk);
        check(adc_cs_n && !adc_rc && !adc_hben, "R1 pins idle in reset",
              {adc_cs_n, adc_rc, adc_hben}, 3'b100);
        check(!req_ready && !smp_valid && !eoc_err, "R1 flags low in reset",
              {req_ready, smp_valid, eoc_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!req_ready, "R1 ready waits after reset", req_ready, 0);
        run(14'h2000, 1'b0, 1'b1, 10, 1'b0);
        run(14'h3FFF, 1'b0, 1'b1, 10, 1'b0);
        run(14'h0000, 1'b1, 1'b1, 5, 1'b0);
        run(14'h1FFF, 1'b0, 1'b0, 8, 1'b0);
        run(14'h2A5C, 1'b0, 1'b0, TMO, 1'b0);
        run(14'h1234, 1'b0, 1'b0, TMO + 1, 1'b0);
        run(14'h0155, 1'b0, 1'b1, 1, 1'b1);
        for (int i = 0; i < 30; i++)
            run(14'($urandom), ($urandom % 4) == 0, 1'($urandom), 1 + int'($urandom % (TMO + 5)), 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", 200000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule